// File: doc/BRIEF.md
# Sponge Squeeze Output Streamer

This unit moves hash output from a sponge state vector onto a 256-bit streaming source once absorption and the final permutation are done. A one-cycle start pulse latches the mode. The unit then reads the rate bytes of the state from byte 0 upward. It packs up to 32 of them into each output beat and marks the valid ones with byte enables. The capacity bytes never appear on the bus.

The two fixed-length modes end by themselves after 32 or 64 bytes and flag the final beat with last. The two extendable-output modes never raise last. When the rate bytes of the current state run out, the unit raises a permutation request and holds it until the external engine answers with a done pulse. It then continues from byte 0 of the new state, and keeps doing so until the stop input ends the run. The permutation engine and the absorb path sit outside this block.

Top module: `sqz_streamer`

## Requirements
- R1: After reset, outValid and permReq are low, and they stay low until start is pulsed.
- R2: A start pulse in idle latches mode. The rates are 136 bytes for mode 00, 72 for 01, 168 for 10 and 136 for 11. Lane i of a beat is outData[8i+7:8i] with enable outKeep[i]. State byte j is stateIn[8j+7:8j]. A beat carries consecutive state bytes, lane 0 first, starting where the previous beat stopped.
- R3: Modes 00 and 01 emit 32 and 64 bytes, taken from state byte 0 upward. The final beat has outLast high and only the enables for its bytes set. After that beat is accepted, outValid drops.
- R4: In modes 10 and 11, outLast is never high and output continues across any number of permutations.
- R5: A beat that reaches the end of the rate is cut short there, with its enables packed from lane 0. After it is accepted, permReq is high and outValid is low until permDone. The next beat starts at byte 0 of the new state.
- R6: Any lane whose enable is low carries zero, so capacity bytes never reach outData.
- R7: While outValid is high and outReady is low, the next cycle keeps outValid high and leaves outData, outKeep and outLast unchanged.
- R8: A stop pulse lets any beat already on the bus complete its handshake, then outValid drops and the unit returns to idle. A stop during a pending permutation ends the run at permDone with no further beat.
- R9: With outReady held high and no permutation pending, a new beat is presented on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins squeezing |
| mode | input | 2 | 00/01 fixed 32/64-byte digest, 10/11 extendable output |
| stop | input | 1 | Ends output after the pending handshake |
| stateIn | input | 1600 | Sponge state, byte j at bits 8j+7:8j |
| permReq | output | 1 | Permutation request, held until permDone |
| permDone | input | 1 | One-cycle pulse: the new state is on stateIn |
| outData | output | 256 | Output beat data |
| outKeep | output | 32 | Output byte enables |
| outValid | output | 1 | Output beat valid |
| outLast | output | 1 | Final beat of a fixed-length digest |
| outReady | input | 1 | Downstream ready |

## Verification
The bench uses the default parameters: 32-byte beats over a 200-byte state. With these values, the 168-byte and 136-byte rates each end in an 8-byte tail beat, so cut-short beats and permutation requests come up within a few beats. The 72-byte rate of the 64-byte digest mode is never exhausted, which tests that the digest limit, not the rate, ends that mode. Varying the permutation latency and the stall pattern places stop pulses during backpressure, at rate boundaries and inside permutations.

// File: rtl/sqz_pkg.sv
`timescale 1ns/1ps
package sqz_pkg;

  typedef enum logic [1:0] {
    MODE_FIX32 = 2'b00,
    MODE_FIX64 = 2'b01,
    MODE_XOF_W = 2'b10,
    MODE_XOF_N = 2'b11
  } sqzMode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STREAM,
    ST_PERM
  } sqzState_e;

  typedef struct packed {
    logic loadMode;
    logic clearCnt;
    logic advance;
  } sqzCtl_t;

  function automatic int rateBytes(input logic [1:0] m);
    case (m)
      2'b00:   return 136;
      2'b01:   return 72;
      2'b10:   return 168;
      default: return 136;
    endcase
  endfunction

  function automatic int digestBytes(input logic [1:0] m);
    case (m)
      2'b00:   return 32;
      2'b01:   return 64;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/sqz_datapath.sv
`timescale 1ns/1ps
module sqz_datapath #(
  parameter int BEAT_BYTES  = 32,
  parameter int STATE_BYTES = 200
) (
  input  logic                       clk,
  input  logic                       rst,
  input  sqz_pkg::sqzCtl_t           ctl,
  input  logic [1:0]                 modeIn,
  input  logic [STATE_BYTES*8-1:0]   stateIn,
  output logic [BEAT_BYTES*8-1:0]    beatData,
  output logic [BEAT_BYTES-1:0]      beatKeep,
  output logic                       beatLast,
  output logic                       atBoundary,
  output logic                       isXof
);
  localparam int OFF_W = $clog2(STATE_BYTES);
  localparam int W     = OFF_W + 1;

  logic [1:0]       modeQ;
  logic [OFF_W-1:0] offQ;
  logic [OFF_W-1:0] emitQ;

  logic [W-1:0] offExt, emitExt, rateB, digB;
  logic [W-1:0] remRate, remDig, lenRate, lenC;

  assign isXof   = modeQ[1];
  assign offExt  = {1'b0, offQ};
  assign emitExt = {1'b0, emitQ};
  assign rateB   = W'(sqz_pkg::rateBytes(modeQ));
  assign digB    = W'(sqz_pkg::digestBytes(modeQ));

  // beat length: limited by beat width, remaining rate, remaining digest
  always_comb begin
    remRate = rateB - offExt;
    lenRate = (remRate < W'(BEAT_BYTES)) ? remRate : W'(BEAT_BYTES);
    remDig  = digB - emitExt;
    lenC    = (!isXof && (remDig < lenRate)) ? remDig : lenRate;
  end

  assign atBoundary = ((offExt + lenC) == rateB);
  assign beatLast   = !isXof && ((emitExt + lenC) == digB);

  for (genvar i = 0; i < BEAT_BYTES; i++) begin : g_lane
    logic [W-1:0] idx;
    assign idx          = offExt + W'(i);
    assign beatKeep[i]  = (W'(i) < lenC);
    assign beatData[8*i +: 8] = beatKeep[i] ? stateIn[{idx, 3'b000} +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ <= 2'b00;
      offQ  <= '0;
      emitQ <= '0;
    end else begin
      if (ctl.loadMode) modeQ <= modeIn;
      if (ctl.clearCnt) begin
        offQ  <= '0;
        emitQ <= '0;
      end else if (ctl.advance) begin
        offQ <= atBoundary ? '0 : OFF_W'(offExt + lenC);
        if (!isXof) emitQ <= OFF_W'(emitExt + lenC);
      end
    end
  end

  AST_OFFSET_IN_RATE: assert property (@(posedge clk) disable iff (rst)
    offExt < rateB); // R2

endmodule

// File: rtl/sqz_ctrl.sv
`timescale 1ns/1ps
module sqz_ctrl (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic              outReady,
  input  logic              permDone,
  input  logic              beatLast,
  input  logic              atBoundary,
  output sqz_pkg::sqzCtl_t  ctl,
  output logic              outValid,
  output logic              permReq
);
  import sqz_pkg::*;

  sqzState_e stateQ, stateD;
  logic      stopPend;
  logic      stopNow;

  assign stopNow = stop | stopPend;

  always_comb begin
    stateD   = stateQ;
    ctl      = '0;
    outValid = 1'b0;
    permReq  = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (start) begin
          ctl.loadMode = 1'b1;
          ctl.clearCnt = 1'b1;
          stateD       = ST_STREAM;
        end
      end
      ST_STREAM: begin
        outValid = 1'b1;
        if (outReady) begin
          ctl.advance = 1'b1;
          if (beatLast || stopNow) stateD = ST_IDLE;
          else if (atBoundary)     stateD = ST_PERM;
        end
      end
      ST_PERM: begin
        permReq = 1'b1;
        if (permDone) stateD = stopNow ? ST_IDLE : ST_STREAM;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ   <= ST_IDLE;
      stopPend <= 1'b0;
    end else begin
      stateQ   <= stateD;
      stopPend <= (stateQ == ST_IDLE) ? 1'b0 : (stopPend | stop);
    end
  end

  AST_PERM_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && atBoundary && !beatLast && !stopNow) |=> (permReq && !outValid)); // R5

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && beatLast) |=> !outValid); // R3

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && stop) |=> (!outValid && !permReq)); // R8

endmodule

// File: rtl/sqz_streamer.sv
`timescale 1ns/1ps
module sqz_streamer #(
  parameter int BEAT_BYTES  = 32,
  parameter int STATE_BYTES = 200
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [1:0]               mode,
  input  logic                     stop,
  input  logic [STATE_BYTES*8-1:0] stateIn,
  output logic                     permReq,
  input  logic                     permDone,
  output logic [BEAT_BYTES*8-1:0]  outData,
  output logic [BEAT_BYTES-1:0]    outKeep,
  output logic                     outValid,
  output logic                     outLast,
  input  logic                     outReady
);
  sqz_pkg::sqzCtl_t ctl;
  logic beatLast, atBoundary, isXof;

  sqz_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .stop       (stop),
    .outReady   (outReady),
    .permDone   (permDone),
    .beatLast   (beatLast),
    .atBoundary (atBoundary),
    .ctl        (ctl),
    .outValid   (outValid),
    .permReq    (permReq)
  );

  sqz_datapath #(
    .BEAT_BYTES  (BEAT_BYTES),
    .STATE_BYTES (STATE_BYTES)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .modeIn     (mode),
    .stateIn    (stateIn),
    .beatData   (outData),
    .beatKeep   (outKeep),
    .beatLast   (beatLast),
    .atBoundary (atBoundary),
    .isXof      (isXof)
  );

  assign outLast = outValid & beatLast;

  AST_HOLD_UNDER_BP: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outKeep) && $stable(outLast))); // R7

  AST_KEEP_PACKED: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outKeep != '0 && ((outKeep + BEAT_BYTES'(1)) & outKeep) == '0)); // R5

  AST_LAST_ONLY_FIXED: assert property (@(posedge clk) disable iff (rst)
    (outValid && outLast) |-> !isXof); // R4

endmodule

// File: tb/sqz_streamer_tb.sv
`timescale 1ns/1ps
module sqz_streamer_tb;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          stop = 1'b0;
  logic [1599:0] stateIn = '0;
  logic          permReq;
  logic          permDone = 1'b0;
  logic [255:0]  outData;
  logic [31:0]   outKeep;
  logic          outValid;
  logic          outLast;
  logic          outReady = 1'b1;

  int nTests = 0;
  int nFail  = 0;

  // scenario globals
  int cSeed = 0;
  int cMode = 0;
  int rMode = 0;
  int permLat = 3;
  int rBlk = 0;
  int cycA = 0;
  bit active = 0;

  // reference cursor
  int eBlk, eOff, eEmit, beats;
  bit stopSeen, noMore, prevStall, expectPerm, expectValid;
  logic [255:0] pD;
  logic [31:0]  pK;
  logic         pL;

  always #2.5 clk = ~clk;

  sqz_streamer u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .stop(stop),
    .stateIn(stateIn), .permReq(permReq), .permDone(permDone),
    .outData(outData), .outKeep(outKeep), .outValid(outValid),
    .outLast(outLast), .outReady(outReady)
  );

  function automatic logic [7:0] sb(int seed, int blk, int j);
    return 8'((j * 13 + blk * 71 + seed * 29 + 5) & 255);
  endfunction

  function automatic logic [1599:0] mkState(int seed, int blk);
    logic [1599:0] s;
    for (int j = 0; j < 200; j++) s[8*j +: 8] = sb(seed, blk, j);
    return s;
  endfunction

  function automatic int bRate(int m);
    case (m)
      0: return 136;
      1: return 72;
      2: return 168;
      default: return 136;
    endcase
  endfunction

  function automatic int bDig(int m);
    return (m == 0) ? 32 : (m == 1) ? 64 : 0;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (60000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  // downstream ready pattern
  initial forever begin
    @(negedge clk);
    cycA++;
    outReady = (rMode == 0) ? 1'b1 : ((cycA % 3) != 1);
  end

  // permutation engine stand-in
  initial forever begin
    @(negedge clk);
    if (permReq) begin
      repeat (permLat) @(negedge clk);
      rBlk++;
      stateIn  = mkState(cSeed, rBlk);
      permDone = 1'b1;
      @(negedge clk);
      permDone = 1'b0;
    end
  end

  // per-cycle reference comparison
  initial forever begin
    @(negedge clk);
    #1;
    if (!rst && active) begin
      chk(!(permReq && outValid), "R5", "valid during permutation", 256'(outValid), 256'(0));
      if (prevStall)
        chk(outValid && outData == pD && outKeep == pK && outLast == pL, "R7",
            "beat changed under backpressure", outData, pD);
      if (expectPerm)
        chk(permReq && !outValid, "R5", "permReq after rate end", 256'(permReq), 256'(1));
      if (expectValid)
        chk(outValid, "R9", "gap between beats", 256'(outValid), 256'(1));
      if (noMore)
        chk(!outValid, "R8", "beat after end of run", 256'(outValid), 256'(0));
      expectPerm  = 0;
      expectValid = 0;
      if (stop) stopSeen = 1;
      if (stop && permReq) noMore = 1;
      if (outValid && outReady && !noMore) begin
        int rate, dig, len;
        bit fixd, el;
        logic [255:0] ed;
        logic [31:0]  ek;
        rate = bRate(cMode);
        dig  = bDig(cMode);
        fixd = (cMode < 2);
        len  = 32;
        if (rate - eOff < len) len = rate - eOff;
        if (fixd && dig - eEmit < len) len = dig - eEmit;
        ed = '0;
        ek = '0;
        for (int i = 0; i < 32; i++)
          if (i < len) begin
            ed[8*i +: 8] = sb(cSeed, eBlk, eOff + i);
            ek[i] = 1'b1;
          end
        el = fixd && (eEmit + len == dig);
        chk(outData == ed, "R2/R6", "beat data", outData, ed);
        chk(outKeep == ek, "R5", "beat keep", 256'(outKeep), 256'(ek));
        chk(outLast == el, fixd ? "R3" : "R4", "beat last", 256'(outLast), 256'(el));
        beats++;
        eOff  += len;
        eEmit += len;
        if (el || stopSeen) noMore = 1;
        else if (eOff == rate) expectPerm = 1;
        else expectValid = 1;
        if (eOff == rate) begin
          eOff = 0;
          eBlk++;
        end
      end
      prevStall = outValid && !outReady;
      pD = outData;
      pK = outKeep;
      pL = outLast;
    end
  end

  task automatic runCase(int m, int seed, int rm, int lat, int stopBeat, bit stopInPerm);
    int guard;
    @(negedge clk);
    active = 0;
    cMode = m; cSeed = seed; rMode = rm; permLat = lat;
    rBlk = 0; stateIn = mkState(seed, 0);
    eBlk = 0; eOff = 0; eEmit = 0; beats = 0;
    stopSeen = 0; noMore = 0; prevStall = 0; expectPerm = 0; expectValid = 0;
    mode = 2'(m);
    start = 1'b1;
    active = 1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    if (m < 2) begin
      while (beats < bDig(m) / 32 && guard < 4000) begin @(negedge clk); guard++; end
      repeat (3) @(negedge clk);
      chk(beats == bDig(m) / 32, "R3", "digest beat count", 256'(beats), 256'(bDig(m) / 32));
      chk(!outValid && !permReq, "R3", "idle after digest", 256'({outValid, permReq}), 256'(0));
    end else begin
      while (beats < stopBeat && guard < 4000) begin @(negedge clk); guard++; end
      if (stopInPerm) begin
        guard = 0;
        while (!permReq && guard < 4000) begin @(negedge clk); guard++; end
      end
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      repeat (lat + 8) @(negedge clk);
      chk(beats >= stopBeat, "R4", "output continued across blocks", 256'(beats), 256'(stopBeat));
      chk(!outValid && !permReq, "R8", "idle after stop", 256'({outValid, permReq}), 256'(0));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(!outValid && !permReq, "R1", "reset state", 256'({outValid, permReq}), 256'(0));
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(!outValid && !permReq, "R1", "idle holds without start", 256'({outValid, permReq}), 256'(0));

    runCase(0, 1, 0, 3, 0, 0);   // R3 32-byte digest, one beat
    runCase(1, 2, 1, 3, 0, 0);   // R3 R7 64-byte digest under backpressure
    runCase(1, 6, 0, 3, 0, 0);   // R9 back-to-back beats
    runCase(2, 3, 0, 4, 14, 0);  // R4 R5 R9 wide XOF across two permutations
    runCase(3, 4, 1, 3, 7, 0);   // R4 R5 R7 narrow XOF with stalls
    runCase(2, 5, 0, 5, 6, 1);   // R8 stop during permutation
    runCase(3, 7, 1, 2, 3, 0);   // R8 stop under backpressure
    runCase(0, 8, 1, 2, 0, 0);   // R2 mode reload after XOF run

    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule